// File: doc/BRIEF.md
# Edge-Interrupt GPIO Bank

This block is a bank of general-purpose pins behind a small memory-mapped register bus. Software sets per-pin direction, output level, edge polarity, interrupt masking and host ownership, always by whole-register writes. It does its own read-modify-write. The bank width is a parameter that is either 16 or 32, and every register has that width.

Each pin input passes through a two-stage synchroniser. The synchronised level is then compared with its value one cycle earlier to detect edges. A pin owned by the host that sees an edge of its selected polarity sets a sticky status bit. Software clears that bit by writing a 1 to it. A single interrupt line is high whenever any status bit is set on a pin that is not masked. A pin the host has not claimed drives nothing and never sets status.

The register bus is plain control traffic with no back-pressure. A write takes effect at the clock edge where `bus_wr` is high. A read is combinational from `bus_addr`. Only exact offsets decode.

Top module: `gpb_bank`

## Requirements
- R1: After reset, the mask register (0x10) and direction register (0x08) read all ones. The output register (0x04), polarity register (0x0C), status register (0x14) and ownership register (0x18) read zero, and `irq` is low.
- R2: Registers at 0x04, 0x08, 0x0C, 0x10 and 0x18 read back the last full value written to them. Offset 0x00 returns the synchronised pin levels and ignores writes.
- R3: A pin is driven (`pin_oe` bit high) only when its ownership bit is 1 and its direction bit is 0 (1 means input). `pin_out` carries the output-register bit on a driven pin and 0 on any other pin.
- R4: On an owned pin, a polarity bit of 1 makes a rising edge set that pin's status bit (bit n of offset 0x14), and a polarity bit of 0 makes a falling edge set it. An edge of the other direction sets nothing. The status bit first reads 1 after the third rising clock edge that follows the pin change, and not after the second.
- R5: A pin whose ownership bit is 0 never sets its status bit, whatever its input does.
- R6: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R7: If a qualifying edge is detected in the same cycle as a clear write to that bit, the bit ends up set.
- R8: `irq` is high exactly when some status bit is 1 and its mask bit is 0. A mask bit of 1 blocks that pin.
- R9: Reads of any offset other than the seven defined ones (for example 0x1C or 0x02) return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, taken at the rising clock edge |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | W | Full-register write data |
| bus_rdata | output | W | Combinational read data for `bus_addr` |
| pin_in | input | W | Asynchronous pin levels |
| pin_out | output | W | Output levels, zero on undriven pins |
| pin_oe | output | W | Per-pin output enable |
| irq | output | 1 | Combined unmasked interrupt |

## Verification
Edge detection is exercised with all six combinations of a polarity setting and a pin transition: rising, falling and steady, each under both polarity values. These separate a correct polarity select from an inverted or a level-sensitive one. Directed cases cover the following:
- a toggle on an unowned pin, which tells ownership gating apart from a simple direction check;
- a clear write that coincides with a detected edge, which exposes the wrong priority;
- masked against unmasked pending status;
- walking ownership and direction patterns on the drive outputs;
- writes to undefined offsets, which separate an exact decode from a partial one.

// File: rtl/gpb_pkg.sv
package gpb_pkg;
  localparam int ADDR_W = 5;
  typedef logic [ADDR_W-1:0] gpb_addr_t;

  localparam gpb_addr_t OFF_LEVEL = 5'h00;
  localparam gpb_addr_t OFF_DRIVE = 5'h04;
  localparam gpb_addr_t OFF_DIR   = 5'h08;
  localparam gpb_addr_t OFF_POL   = 5'h0C;
  localparam gpb_addr_t OFF_MASK  = 5'h10;
  localparam gpb_addr_t OFF_STAT  = 5'h14;
  localparam gpb_addr_t OFF_OWN   = 5'h18;

  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/gpb_sync.sv
module gpb_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage[0] <= '0;
          else        stage[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage[s] <= '0;
          else        stage[s] <= stage[s-1];
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/gpb_edge.sv
module gpb_edge #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] own,
  input  logic [W-1:0] clr,
  output logic [W-1:0] evt,
  output logic [W-1:0] sts
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;

  generate
    for (genvar i = 0; i < W; i++) begin : g_pin
      logic rise, fall;
      assign rise   = lvl[i] & ~prev_q[i];
      assign fall   = ~lvl[i] & prev_q[i];
      assign evt[i] = own[i] & (pol[i] ? rise : fall);

      // A detected edge wins over a clear in the same cycle.
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)      sts[i] <= 1'b0;
        else if (evt[i]) sts[i] <= 1'b1;
        else if (clr[i]) sts[i] <= 1'b0;
    end
  endgenerate
endmodule

// File: rtl/gpb_regs.sv
module gpb_regs
  import gpb_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  gpb_addr_t    addr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] sts,
  output logic [W-1:0] rdata,
  output logic [W-1:0] drive,
  output logic [W-1:0] dir,
  output logic [W-1:0] pol,
  output logic [W-1:0] mask,
  output logic [W-1:0] own,
  output logic [W-1:0] clr
);
  logic hit_drive, hit_dir, hit_pol, hit_mask, hit_own, hit_stat;

  assign hit_drive = wr_en && addr == OFF_DRIVE;
  assign hit_dir   = wr_en && addr == OFF_DIR;
  assign hit_pol   = wr_en && addr == OFF_POL;
  assign hit_mask  = wr_en && addr == OFF_MASK;
  assign hit_own   = wr_en && addr == OFF_OWN;
  assign hit_stat  = wr_en && addr == OFF_STAT;

  assign clr = hit_stat ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive <= '0;
      dir   <= '1;
      pol   <= '0;
      mask  <= '1;
      own   <= '0;
    end else begin
      if (hit_drive) drive <= wdata;
      if (hit_dir)   dir   <= wdata;
      if (hit_pol)   pol   <= wdata;
      if (hit_mask)  mask  <= wdata;
      if (hit_own)   own   <= wdata;
    end
  end

  always_comb begin
    unique case (addr)
      OFF_LEVEL: rdata = lvl;
      OFF_DRIVE: rdata = drive;
      OFF_DIR:   rdata = dir;
      OFF_POL:   rdata = pol;
      OFF_MASK:  rdata = mask;
      OFF_STAT:  rdata = sts;
      OFF_OWN:   rdata = own;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpb_bank.sv
module gpb_bank
  import gpb_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      pin_in,
  output logic [W-1:0]      pin_out,
  output logic [W-1:0]      pin_oe,
  output logic              irq
);
  logic [W-1:0] lvl, drive_q, dir_q, pol_q, mask_q, own_q, clr, evt, sts_q;

  gpb_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(lvl)
  );

  gpb_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .lvl(lvl), .sts(sts_q), .rdata(bus_rdata),
    .drive(drive_q), .dir(dir_q), .pol(pol_q), .mask(mask_q),
    .own(own_q), .clr(clr)
  );

  gpb_edge #(.W(W)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .pol(pol_q), .own(own_q),
    .clr(clr), .evt(evt), .sts(sts_q)
  );

  assign pin_oe  = own_q & ~dir_q;
  assign pin_out = drive_q & pin_oe;
  assign irq     = |(sts_q & ~mask_q);
endmodule

// File: rtl/gpb_bank_chk.sv
module gpb_bank_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         irq,
  input logic [W-1:0] sts,
  input logic [W-1:0] mask,
  input logic [W-1:0] own,
  input logic [W-1:0] evt,
  input logic [W-1:0] clr,
  input logic [W-1:0] pin_oe,
  input logic [W-1:0] pin_out
);
  assert_no_stray_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_oe & ~own) == '0) && ((pin_out & ~pin_oe) == '0));

  assert_owned_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sts & ~$past(sts) & ~$past(own)) == '0));

  assert_clear_needs_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(sts) & ~sts & ~$past(clr)) == '0));

  assert_edge_beats_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt & clr) != '0) |=> ((sts & $past(evt & clr)) == $past(evt & clr)));

  assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (!$stable(sts) || !$stable(mask)));
endmodule

bind gpb_bank gpb_bank_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .sts(sts_q), .mask(mask_q),
  .own(own_q), .evt(evt), .clr(clr), .pin_oe(pin_oe), .pin_out(pin_out)
);

// File: tb/tb_gpb_bank.sv
module tb_gpb_bank;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  // Each entry: {polarity, start level, end level, expected status}
  localparam logic [3:0] VEC [6] = '{
    4'b1011, 4'b1100, 4'b0101, 4'b0010, 4'b1000, 4'b0110
  };

  logic clk = 0, rst_n = 0, bus_wr = 0, irq;
  logic [4:0] bus_addr = '0;
  logic [W-1:0] bus_wdata = '0, bus_rdata, pin_in = '0, pin_out, pin_oe;
  int checks = 0, fails = 0;
  logic done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpb_bank #(.W(W)) dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [W-1:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [W-1:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic wait_neg(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] v;
    wait_neg(3); rst_n = 1; @(negedge clk);
    // R1 reset state
    rd(5'h10, v); chk("R1 mask", v, 16'hFFFF);
    rd(5'h08, v); chk("R1 dir", v, 16'hFFFF);
    rd(5'h04, v); chk("R1 drive", v, 0);
    rd(5'h0C, v); chk("R1 pol", v, 0);
    rd(5'h14, v); chk("R1 status", v, 0);
    rd(5'h18, v); chk("R1 own", v, 0);
    chk("R1 irq", irq, 0);

    // R4 polarity table, pin 0 owned and unmasked
    wr(5'h18, 16'h0001); wr(5'h10, 16'hFFFE);
    for (int i = 0; i < 6; i++) begin
      wr(5'h0C, {15'd0, VEC[i][3]});
      pin_in[0] = VEC[i][2];
      wait_neg(4);
      wr(5'h14, 16'hFFFF);
      pin_in[0] = VEC[i][1];
      wait_neg(4);
      rd(5'h14, v); chk("R4 table status", v[0], VEC[i][0]);
      chk("R8 table irq", irq, VEC[i][0]);
    end
    wr(5'h14, 16'hFFFF);

    // R4 latency: rising on pin 0, polarity rising
    wr(5'h0C, 16'h0001); pin_in[0] = 0; wait_neg(4); wr(5'h14, 16'hFFFF);
    pin_in[0] = 1; wait_neg(2);
    rd(5'h14, v); chk("R4 not after 2nd edge", v[0], 0);
    wait_neg(1);
    rd(5'h14, v); chk("R4 set after 3rd edge", v[0], 1);

    // R8 masking
    wr(5'h10, 16'hFFFF); #1; chk("R8 masked irq", irq, 0);
    wr(5'h10, 16'hFFFE); #1; chk("R8 unmasked irq", irq, 1);

    // R6 write 0 keeps, write 1 clears
    wr(5'h14, 16'h0000); rd(5'h14, v); chk("R6 zero write keeps", v[0], 1);
    wr(5'h14, 16'h0001); rd(5'h14, v); chk("R6 one write clears", v[0], 0);
    chk("R8 irq after clear", irq, 0);

    // R7 edge coincides with clear
    pin_in[0] = 0; wait_neg(4);
    @(negedge clk) pin_in[0] = 1;
    @(negedge clk);
    @(negedge clk) begin bus_wr = 1; bus_addr = 5'h14; bus_wdata = 16'h0001; end
    @(negedge clk) bus_wr = 0;
    rd(5'h14, v); chk("R7 edge wins", v[0], 1);
    wr(5'h14, 16'hFFFF);

    // R5 unowned pin 8 toggles, rising polarity, unmasked
    wr(5'h0C, 16'hFFFF); wr(5'h10, 16'h0000);
    pin_in[8] = 1; wait_neg(4); pin_in[8] = 0; wait_neg(4); pin_in[8] = 1; wait_neg(4);
    rd(5'h14, v); chk("R5 unowned status", v[8], 0);
    chk("R5 unowned irq", irq, 0);

    // R2 read-back and level read
    wr(5'h0C, 16'h5A3C); rd(5'h0C, v); chk("R2 pol readback", v, 16'h5A3C);
    wr(5'h10, 16'hFFFF);
    pin_in = 16'hA5A5; wait_neg(3);
    rd(5'h00, v); chk("R2 level", v, 16'hA5A5);
    wr(5'h00, 16'h1234); rd(5'h00, v); chk("R2 level write ignored", v, 16'hA5A5);

    // R3 drive gating
    wr(5'h04, 16'hF0F0); wr(5'h08, 16'h0000); wr(5'h18, 16'h0000);
    chk("R3 unowned oe", pin_oe, 0); chk("R3 unowned out", pin_out, 0);
    wr(5'h18, 16'h00FF); wr(5'h08, 16'h000F);
    chk("R3 oe", pin_oe, 16'h00F0); chk("R3 out", pin_out, 16'h00F0);
    rd(5'h04, v); chk("R2 drive readback", v, 16'hF0F0);

    // R9 undefined offsets
    wr(5'h1C, 16'hFFFF); rd(5'h1C, v); chk("R9 read 0x1C", v, 0);
    wr(5'h02, 16'h0000); rd(5'h02, v); chk("R9 read 0x02", v, 0);
    rd(5'h18, v); chk("R9 own untouched", v, 16'h00FF);
    rd(5'h10, v); chk("R9 mask untouched", v, 16'hFFFF);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule